// File: doc/BRIEF.md
# Synchronous clock stop controller

This block gates a set of clock outputs in response to active-low stop and power-down requests. Each output stops and restarts only on whole-cycle boundaries, so no output ever shows a shortened high phase. The outputs fall into two clock domains. A fast group is driven from the fast source clock and has its own stop request. A bus group is driven from a free-running bus source clock, and that same clock samples the bus stop request. One extra bus-rate output, the free bus output, ignores the bus stop request. A global power-down request overrides both stop requests and also parks the free bus output.

Every request passes through a two-flop synchroniser in the destination domain, clocked on the rising edge. It then reaches a per-output enable flop that updates on the falling edge of the source clock. Each output is the source clock ANDed with its enable. An enable can only change while its clock is low, so each output either gives a full high phase or stays low for the whole cycle. The asynchronous reset is released through a synchroniser in each domain, and all enables reset to the stopped state.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output is held low.
- R2: When `fast_stop_n` falls half a fast cycle before a rising fast edge, the fast outputs still produce exactly two more full pulses and then stay low.
- R3: When `fast_stop_n` rises half a fast cycle before a rising fast edge, the first fast output pulse starts 2.5 fast cycles later. After that, the fast outputs produce one pulse per fast cycle.
- R4: Every high phase on every output lasts exactly half a period of its source clock. No runt pulse ever appears.
- R5: The bus stop request is sampled on rising edges of the bus clock. When `bus_stop_n` falls half a bus cycle before a rising bus edge, the gated bus outputs give exactly two more full pulses. They then stay at logic 0 for as long as `bus_stop_n` stays low.
- R6: When `bus_stop_n` rises half a bus cycle before a rising bus edge, the first gated bus pulse starts 2.5 bus cycles later. After that, the gated bus outputs produce one pulse per bus cycle.
- R7: While `pwrdn_n` is high, `bus_free_out` pulses once per bus cycle whatever the level of `bus_stop_n`.
- R8: The fast stop request has no effect on the bus-domain outputs, and the bus stop request has no effect on the fast outputs.
- R9: A low `pwrdn_n` holds all outputs low, including `bus_free_out`, even while both stop requests are high. The fast outputs give exactly two more pulses after the request, in the same way as R2.
- R10: When `pwrdn_n` returns high, each group resumes according to its own stop request. The gated bus outputs stay low if `bus_stop_n` is still low, while the fast outputs and `bus_free_out` run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast source clock |
| bus_clk | input | 1 | Free-running bus source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_stop_n | input | 1 | Active-low stop request for the fast group |
| bus_stop_n | input | 1 | Active-low stop request for the gated bus group |
| pwrdn_n | input | 1 | Active-low global power-down request |
| fast_clk_out | output | N_FAST | Gated fast clock outputs |
| bus_clk_out | output | N_BUS | Gated bus clock outputs |
| bus_free_out | output | 1 | Bus-rate output that is exempt from the bus stop |

## Verification
The bench changes each request on a falling edge of the clock in the request's domain. It then counts output rising edges over a window that starts at that change.

For a stop request, two pulses are due, at 0.5 and 1.5 cycles after the change. The window is six cycles long, so its count must be exactly 2. For a restart, a single pulse is due at 2.5 cycles, so the count over a three-cycle window must be exactly 1.

Every window ends on a falling edge, so no output edge ever coincides with a window boundary. Steady states (running, stopped, or unaffected by the other domain's request) are counted only after a settling gap of several cycles. Pulse widths are measured on every high phase for the whole run.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  localparam int SYNC_STAGES_DEF = 2;

  // Power-down dominates: a group runs only when neither request asks it to stop.
  function automatic logic run_request(input logic stop_n, input logic pwrdn_n);
    return stop_n & pwrdn_n;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [WIDTH-1:0] gclk
);

  // One enable flop per output, each updated only while the clock is low.
  for (genvar g = 0; g < WIDTH; g++) begin : g_out
    logic en_q;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= run;
    end
    assign gclk[g] = clk & en_q;
  end

endmodule

// File: rtl/clkstop_domain.sv
`timescale 1ns/1ps
module clkstop_domain #(
  parameter int N_OUT       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  output logic [N_OUT-1:0] gclk
);

  logic rst_sync_n;
  logic run_sync;

  clkstop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  clkstop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (run_req),
    .q     (run_sync)
  );

  clkstop_gate #(.WIDTH(N_OUT)) u_gate (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run_sync),
    .gclk  (gclk)
  );

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_FAST      = 2,
  parameter int N_BUS       = 5,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              fast_clk,
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              fast_stop_n,
  input  logic              bus_stop_n,
  input  logic              pwrdn_n,
  output logic [N_FAST-1:0] fast_clk_out,
  output logic [N_BUS-1:0]  bus_clk_out,
  output logic              bus_free_out
);

  logic fast_run_req;
  logic bus_run_req;
  logic free_run_req;

  assign fast_run_req = run_request(fast_stop_n, pwrdn_n);
  assign bus_run_req  = run_request(bus_stop_n,  pwrdn_n);
  assign free_run_req = run_request(1'b1,        pwrdn_n);

  clkstop_domain #(.N_OUT(N_FAST), .SYNC_STAGES(SYNC_STAGES)) u_fast (
    .clk     (fast_clk),
    .rst_n   (rst_n),
    .run_req (fast_run_req),
    .gclk    (fast_clk_out)
  );

  clkstop_domain #(.N_OUT(N_BUS), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk     (bus_clk),
    .rst_n   (rst_n),
    .run_req (bus_run_req),
    .gclk    (bus_clk_out)
  );

  clkstop_domain #(.N_OUT(1), .SYNC_STAGES(SYNC_STAGES)) u_free (
    .clk     (bus_clk),
    .rst_n   (rst_n),
    .run_req (free_run_req),
    .gclk    (bus_free_out)
  );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
  parameter int N_FAST = 2,
  parameter int N_BUS  = 5
) (
  input logic              fast_clk,
  input logic              bus_clk,
  input logic              rst_n,
  input logic              fast_stop_n,
  input logic              bus_stop_n,
  input logic              pwrdn_n,
  input logic [N_FAST-1:0] fast_clk_out,
  input logic [N_BUS-1:0]  bus_clk_out,
  input logic              bus_free_out
);

  // Falling edges of the bus clock seen since reset, saturating.
  logic [2:0] bus_age_q;
  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n)                 bus_age_q <= '0;
    else if (bus_age_q != 3'd7) bus_age_q <= bus_age_q + 3'd1;
  end

  // R1: outputs stay low during reset
  a_r1_reset_low: assert property (@(negedge fast_clk)
    !rst_n |-> fast_clk_out == '0);

  // R2: a stop request held for four falling-edge samples leaves the fast group parked
  a_r2_fast_parked: assert property (@(negedge fast_clk) disable iff (!rst_n)
    (!fast_stop_n && !$past(fast_stop_n) && !$past(fast_stop_n, 2) && !$past(fast_stop_n, 3))
    |-> fast_clk_out == '0);

  // R5: a held bus stop parks the gated bus group
  a_r5_bus_parked: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (!bus_stop_n && !$past(bus_stop_n) && !$past(bus_stop_n, 2) && !$past(bus_stop_n, 3))
    |-> bus_clk_out == '0);

  // R7: the free bus output is high in every high phase once settled, whatever bus_stop_n
  a_r7_free_runs: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (bus_age_q == 3'd7 && pwrdn_n && $past(pwrdn_n) && $past(pwrdn_n, 2) && $past(pwrdn_n, 3))
    |-> bus_free_out);

  // R9: a held power-down parks the fast group even with fast_stop_n high
  a_r9_pwrdn_fast: assert property (@(negedge fast_clk) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
    |-> fast_clk_out == '0);

  // R9: a held power-down parks the free bus output too
  a_r9_pwrdn_free: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
    |-> !bus_free_out);

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_FAST(N_FAST), .N_BUS(N_BUS)) u_chk (
  .fast_clk     (fast_clk),
  .bus_clk      (bus_clk),
  .rst_n        (rst_n),
  .fast_stop_n  (fast_stop_n),
  .bus_stop_n   (bus_stop_n),
  .pwrdn_n      (pwrdn_n),
  .fast_clk_out (fast_clk_out),
  .bus_clk_out  (bus_clk_out),
  .bus_free_out (bus_free_out)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_PERIOD = 3 * CLK_PERIOD;
  localparam int NF = 2;
  localparam int NB = 5;

  logic fast_clk = 1'b0;
  logic bus_clk  = 1'b0;
  logic rst_n, fast_stop_n, bus_stop_n, pwrdn_n;
  logic [NF-1:0] fast_clk_out;
  logic [NB-1:0] bus_clk_out;
  logic bus_free_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  clkstop_ctrl #(.N_FAST(NF), .N_BUS(NB)) i_clkstop_ctrl (
    .fast_clk(fast_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .fast_stop_n(fast_stop_n), .bus_stop_n(bus_stop_n), .pwrdn_n(pwrdn_n),
    .fast_clk_out(fast_clk_out), .bus_clk_out(bus_clk_out), .bus_free_out(bus_free_out)
  );

  always #(CLK_PERIOD/2) fast_clk = ~fast_clk;
  initial begin
    #7;
    forever begin
      bus_clk = ~bus_clk;
      #(BUS_PERIOD/2);
    end
  end

  // Edge counters and pulse-width monitor
  int cnt_f [NF];
  int cnt_b [NB];
  int cnt_r;
  longint rise_f [NF];
  longint rise_b [NB];
  longint rise_r;
  logic [NF-1:0] prev_f = '0;
  logic [NB-1:0] prev_b = '0;
  logic prev_r = 1'b0;
  int runts = 0;
  int pulses = 0;

  initial begin
    for (int k = 0; k < NF; k++) cnt_f[k] = 0;
    for (int k = 0; k < NB; k++) cnt_b[k] = 0;
    cnt_r = 0;
  end

  always @(fast_clk_out or bus_clk_out or bus_free_out) begin
    for (int k = 0; k < NF; k++) begin
      if (fast_clk_out[k] && !prev_f[k]) begin cnt_f[k]++; rise_f[k] = $time; end
      else if (!fast_clk_out[k] && prev_f[k]) begin
        pulses++;
        if ($time - rise_f[k] != CLK_PERIOD/2) runts++;
      end
    end
    for (int k = 0; k < NB; k++) begin
      if (bus_clk_out[k] && !prev_b[k]) begin cnt_b[k]++; rise_b[k] = $time; end
      else if (!bus_clk_out[k] && prev_b[k]) begin
        pulses++;
        if ($time - rise_b[k] != BUS_PERIOD/2) runts++;
      end
    end
    if (bus_free_out && !prev_r) begin cnt_r++; rise_r = $time; end
    else if (!bus_free_out && prev_r) begin
      pulses++;
      if ($time - rise_r != BUS_PERIOD/2) runts++;
    end
    prev_f = fast_clk_out;
    prev_b = bus_clk_out;
    prev_r = bus_free_out;
  end

  function automatic int count_of(int grp, int b);
    if (grp == 0) return cnt_f[b];
    if (grp == 1) return cnt_b[b];
    return cnt_r;
  endfunction

  function automatic int width_of(int grp);
    if (grp == 0) return NF;
    if (grp == 1) return NB;
    return 1;
  endfunction

  // Scoreboard
  typedef struct {
    string  req;
    int     grp;
    int     bitn;
    int     base;
    int     expct;
    longint due;
  } item_t;

  item_t q[$];
  bit mon_busy = 0;

  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      mon_busy = 1;
      it = q.pop_front();
      if ($time < it.due) #(it.due - $time);
      checks++;
      if (count_of(it.grp, it.bitn) - it.base != it.expct) begin
        failures++;
        $display("FAIL %s group %0d bit %0d edges actual=%0d expected=%0d",
                 it.req, it.grp, it.bitn, count_of(it.grp, it.bitn) - it.base, it.expct);
      end
      mon_busy = 0;
    end
  end

  task automatic push_group(string req, int grp, int periods, int expct);
    int per = (grp == 0) ? CLK_PERIOD : BUS_PERIOD;
    for (int b = 0; b < width_of(grp); b++) begin
      item_t it;
      it.req = req; it.grp = grp; it.bitn = b;
      it.base = count_of(grp, b); it.expct = expct;
      it.due = $time + longint'(periods * per);
      q.push_back(it);
    end
  endtask

  task automatic drain();
    #1;
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic align(int grp);
    if (grp == 0) @(negedge fast_clk);
    else          @(negedge bus_clk);
  endtask

  task automatic expect_edges(string req, int grp, int periods, int expct);
    align(grp);
    push_group(req, grp, periods, expct);
    drain();
  endtask

  task automatic settle();
    repeat (6) @(negedge bus_clk);
  endtask

  initial begin
    rst_n = 0; fast_stop_n = 1; bus_stop_n = 1; pwrdn_n = 1;
    // R1: nothing toggles during reset
    push_group("R1", 0, 8, 0);
    push_group("R1", 2, 2, 0);
    push_group("R1", 1, 2, 0);
    drain();
    @(negedge fast_clk) rst_n = 1;
    settle();
    expect_edges("R3", 0, 8, 8);
    expect_edges("R7", 2, 4, 4);
    expect_edges("R6", 1, 4, 4);

    // R2: fast stop, two more pulses then parked
    align(0); fast_stop_n = 0;
    push_group("R2", 0, 6, 2);
    drain();
    expect_edges("R2", 0, 4, 0);
    expect_edges("R8", 1, 4, 4);
    expect_edges("R8", 2, 4, 4);
    // R3: restart with first pulse at 2.5 cycles
    align(0); fast_stop_n = 1;
    push_group("R3", 0, 3, 1);
    drain();
    expect_edges("R3", 0, 8, 8);

    // R5: bus stop, free output keeps running
    align(1); bus_stop_n = 0;
    push_group("R5", 1, 6, 2);
    push_group("R7", 2, 6, 6);
    drain();
    expect_edges("R5", 1, 4, 0);
    expect_edges("R8", 0, 8, 8);
    // R6: bus restart
    align(1); bus_stop_n = 1;
    push_group("R6", 1, 3, 1);
    drain();
    expect_edges("R6", 1, 4, 4);

    // R9: power-down overrides high stop requests
    align(0); pwrdn_n = 0;
    push_group("R9", 0, 6, 2);
    drain();
    settle();
    expect_edges("R9", 0, 4, 0);
    expect_edges("R9", 1, 4, 0);
    expect_edges("R9", 2, 4, 0);

    // R10: release power-down while the bus stop is still active
    align(1); bus_stop_n = 0;
    settle();
    align(0); pwrdn_n = 1;
    settle();
    expect_edges("R10", 0, 8, 8);
    expect_edges("R10", 2, 4, 4);
    expect_edges("R10", 1, 4, 0);
    align(1); bus_stop_n = 1;
    settle();
    expect_edges("R10", 1, 4, 4);

    // R4: every high phase had full width
    checks++;
    if (runts != 0 || pulses == 0) begin
      failures++;
      $display("FAIL R4 runt pulses actual=%0d expected=0 (pulses seen %0d)", runts, pulses);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(longint'(200000) * CLK_PERIOD);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule